// File: doc/BRIEF.md
# DMA Channel Control and Status Register with Per-Bit Masked Writes

This block is the 32-bit control and status register of one descriptor-driven DMA channel. It sits on a plain register bus with an address, a write strobe, write data and combinational read data. Software writes through a control address and reads the result back through a status address. A control write carries a per-bit enable in its upper half and the new values in its lower half. Software can therefore set or clear any chosen group of status bits in one write, with no read-modify-write.

The register holds these bits: the channel state bits (run, pause, flush, wake, dead), the engine's active indication, a branch-taken flag, and eight device status bits. A small engine state machine models how the channel acknowledges requests. It has three states: `ST_IDLE`, `ST_RUN` and `ST_DRAIN`. The named transitions are:
- start (`ST_IDLE` to `ST_RUN` when run=1 and pause=0)
- quiesce (`ST_RUN` to `ST_DRAIN` when run=0, pause=1 or flush=1)
- drain-done (`ST_DRAIN` to `ST_IDLE` after `DRAIN_CYC` cycles, which also self-clears flush)
- abort (any state to `ST_IDLE` when a control write clears active)

A device-side port can also load the eight device status bits.

Top module: `dma_chan_csr`

## Requirements
- R1: A bus write to the control address changes status bit i (0..15) only when bit i+16 of the written word is 1, and the new value is bit i of the written word; other stored bits keep their values.
- R2: The status word layout is: run bit 15, pause bit 14, flush bit 13, wake bit 12, dead bit 11, active bit 10, branch-taken bit 8, device status bits 7..0 (byte 0 of the bus word).
- R3: Status bits 9 and 31..16 always read 0, and writes to them have no effect.
- R4: When the status shows run=1 and pause=0 while the engine is idle, active reads 1 one cycle later; while pause=1, active stays 0.
- R5: When run is cleared or pause is set while running, active keeps reading 1 for `DRAIN_CYC`+1 cycles after the write and then reads 0; flush reads 0 from that same cycle.
- R6: A stop write (enable run and flush, both values 0) leads to active=0 and flush=0 within `DRAIN_CYC`+1 cycles.
- R7: A control write that enables the active bit with value 0 forces active to 0 in the next cycle. A reset write (enable run, pause, flush, wake, dead, active, all values 0) shows run=0 and active=0 in the next cycle. Writing 1 to active has no effect.
- R8: `dev_stat_we` loads bits 7..0 from `dev_stat_wdata`. For each bit enabled by a same-cycle control write, the bus value wins.
- R9: While `rst_n` is low, every status bit is 0 and `chan_active` is 0.
- R10: Reads at any address other than the status address return 0, the control address included. Bus writes to addresses other than the control address change nothing.
- R11: `chan_active` always equals status bit 10.
- R12: Setting flush while running starts a drain. After the drain, flush reads 0 and active is 0 for one cycle. If run is still 1 and pause is 0, active returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: enables in 31..16, values in 15..0 |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| dev_stat_we | input | 1 | Device-side load of the device status byte |
| dev_stat_wdata | input | 8 | Device status value |
| chan_active | output | 1 | Engine active indication |

## Verification
The masking logic is swept in two ways:
- single-bit set and clear writes on every position of the lower half
- a long pseudo-random stream of enable/value words, checked against an arithmetic model

Together these separate a correct per-bit enable from a swapped half, a missing bit and a stored reserved bit. The engine is driven with four request patterns:
- start
- stop (with flush)
- flush-while-running
- pause
Each pattern has its active timeline sampled every cycle, which separates an off-by-one drain length from a missed restart or a flush that never self-clears. A reset-style write while running, and a device write that collides with a partly enabled bus write, exercise the abort path and the per-bit priority.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int unsigned HALF_W   = 16;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned DEV_W    = 8;

    localparam int unsigned RUN_BIT  = 15;
    localparam int unsigned PAUSE_BIT = 14;
    localparam int unsigned FLUSH_BIT = 13;
    localparam int unsigned WAKE_BIT = 12;
    localparam int unsigned DEAD_BIT = 11;
    localparam int unsigned ACT_BIT  = 10;
    localparam int unsigned BT_BIT   = 8;

    // Bits held in storage; active comes from the engine, bit 9 is reserved.
    localparam logic [HALF_W-1:0] KEEP_MASK = 16'hF9FF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_e;

endpackage

// File: rtl/dma_csr_merge.sv
module dma_csr_merge #(
    parameter int unsigned         W    = 16,
    parameter logic [W-1:0]        KEEP = '1
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] bus_hit_i,
    input  logic [W-1:0] bus_val_i,
    input  logic [W-1:0] aux_hit_i,
    input  logic [W-1:0] aux_val_i,
    output logic [W-1:0] nxt_o
);

    // Per-bit selection: bus enable first, then the side source, else hold.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic sel;
        assign sel      = bus_hit_i[i] ? bus_val_i[i]
                        : (aux_hit_i[i] ? aux_val_i[i] : cur_i[i]);
        assign nxt_o[i] = KEEP[i] & sel;
    end

endmodule

// File: rtl/dma_csr_engine.sv
module dma_csr_engine
    import dma_csr_pkg::*;
#(
    parameter int unsigned DRAIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic pause_i,
    input  logic flush_i,
    input  logic abort_i,
    output logic active_o,
    output logic drain_done_o
);

    localparam int unsigned     CNT_W = (DRAIN_CYC < 2) ? 1 : $clog2(DRAIN_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DRAIN_CYC - 1);

    eng_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (abort_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (run_i && !pause_i) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!run_i || pause_i || flush_i) begin
                        st_d  = ST_DRAIN;
                        cnt_d = LOAD;
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q == '0) st_d = ST_IDLE;
                    else             cnt_d = cnt_q - 1'b1;
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        active_o     = (st_q == ST_RUN) || (st_q == ST_DRAIN);
        drain_done_o = (st_q == ST_DRAIN) && (cnt_q == '0) && !abort_i;
    end

    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && run_i && !pause_i && !abort_i) |=> active_o);

    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !active_o);

    a_r5_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && (!run_i || pause_i || flush_i) && !abort_i)
        |=> (st_q == ST_DRAIN && active_o));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN && !abort_i && cnt_q != '0)
        |=> (st_q == ST_DRAIN && cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    a_r12_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done_o |=> (st_q == ST_IDLE && !active_o));

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned STAT_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       word_i,
    output logic [31:0]       rdata_o
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    always_comb begin
        rdata_o = (addr_i == STAT_A) ? word_i : 32'h0;
    end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned STAT_ADDR = 1,
    parameter int unsigned DRAIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dev_stat_we,
    input  logic [7:0]        dev_stat_wdata,
    output logic              chan_active
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic              ctrl_wr;
    logic [HALF_W-1:0] bus_hit, bus_val, aux_hit, aux_val;
    logic [HALF_W-1:0] stat_q, stat_d;
    logic              abort, active, drain_done;
    logic [WORD_W-1:0] stat_word;

    assign ctrl_wr = bus_we && (bus_addr == CTRL_A);
    assign bus_hit = ctrl_wr ? bus_wdata[WORD_W-1:HALF_W] : '0;
    assign bus_val = bus_wdata[HALF_W-1:0];
    assign abort   = ctrl_wr && bus_wdata[HALF_W+ACT_BIT] && !bus_wdata[ACT_BIT];

    always_comb begin
        aux_hit              = '0;
        aux_val              = '0;
        aux_hit[DEV_W-1:0]   = {DEV_W{dev_stat_we}};
        aux_val[DEV_W-1:0]   = dev_stat_wdata;
        aux_hit[FLUSH_BIT]   = drain_done;
    end

    dma_csr_merge #(.W(HALF_W), .KEEP(KEEP_MASK)) merge_i (
        .cur_i     (stat_q),
        .bus_hit_i (bus_hit),
        .bus_val_i (bus_val),
        .aux_hit_i (aux_hit),
        .aux_val_i (aux_val),
        .nxt_o     (stat_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    dma_csr_engine #(.DRAIN_CYC(DRAIN_CYC)) engine_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (stat_q[RUN_BIT]),
        .pause_i      (stat_q[PAUSE_BIT]),
        .flush_i      (stat_q[FLUSH_BIT]),
        .abort_i      (abort),
        .active_o     (active),
        .drain_done_o (drain_done)
    );

    always_comb begin
        stat_word          = {{(WORD_W-HALF_W){1'b0}}, stat_q};
        stat_word[ACT_BIT] = active;
    end

    dma_csr_rdmux #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) rdmux_i (
        .addr_i  (bus_addr),
        .word_i  (stat_word),
        .rdata_o (bus_rdata)
    );

    assign chan_active = active;

    a_r1_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && bus_wdata[HALF_W+RUN_BIT])
        |=> stat_q[RUN_BIT] == $past(stat_q[RUN_BIT]));

    a_r1_run_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[HALF_W+RUN_BIT])
        |=> stat_q[RUN_BIT] == $past(bus_wdata[RUN_BIT]));

    a_r8_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[HALF_W] && dev_stat_we)
        |=> stat_q[0] == $past(bus_wdata[0]));

    a_r8_dev_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_stat_we && !(ctrl_wr && bus_wdata[HALF_W+DEV_W-1:HALF_W] != '0))
        |=> stat_q[DEV_W-1:0] == $past(dev_stat_wdata));

    a_r12_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_done && !(ctrl_wr && bus_wdata[HALF_W+FLUSH_BIT]))
        |=> !stat_q[FLUSH_BIT]);

endmodule

// File: tb/dma_chan_csr_tb_top.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CTRL   = 0;
    localparam int unsigned STAT   = 1;
    localparam int unsigned D      = 3;
    localparam logic [15:0] WMASK  = 16'h79FF; // bus-writable bits with run left out

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = ADDR_W'(STAT);
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              dev_stat_we = 1'b0;
    logic [7:0]        dev_stat_wdata = '0;
    logic              chan_active;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    dma_chan_csr #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL), .STAT_ADDR(STAT), .DRAIN_CYC(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_stat_we(dev_stat_we),
        .dev_stat_wdata(dev_stat_wdata), .chan_active(chan_active)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input int unsigned a, output logic [31:0] v);
        bus_addr = ADDR_W'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_wr(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_addr = ADDR_W'(STAT);
    endtask

    task automatic both_wr(input logic [31:0] d, input logic [7:0] dv);
        @(negedge clk);
        bus_addr = ADDR_W'(CTRL); bus_we = 1'b1; bus_wdata = d;
        dev_stat_we = 1'b1; dev_stat_wdata = dv;
        @(negedge clk);
        bus_we = 1'b0; dev_stat_we = 1'b0; bus_addr = ADDR_W'(STAT);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic act_check(input string tag, input logic exp);
        logic [31:0] v;
        rd(STAT, v);
        check(tag, {31'b0, v[10]}, {31'b0, exp});
        check({tag, " R11 port"}, {31'b0, chan_active}, {31'b0, v[10]});
    endtask

    task automatic run_all();
        logic [31:0] v;
        logic [15:0] exp_s;
        logic [31:0] seed;
        // R9 reset state
        repeat (3) @(negedge clk);
        rd(STAT, v);
        check("R9 reset status", v, 32'h0);
        check("R9 reset active", {31'b0, chan_active}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(CTRL, v);
        check("R10 control reads 0", v, 32'h0);

        // R1/R2/R3 single-bit set then clear on every lower position but run
        exp_s = '0;
        for (int i = 0; i < 15; i++) begin
            bus_wr(CTRL, (32'h1 << (i + 16)) | (32'h1 << i));
            exp_s = exp_s | (WMASK & (16'h1 << i));
            rd(STAT, v);
            check($sformatf("R1 R3 set bit %0d", i), v, {16'h0, exp_s});
            bus_wr(CTRL, 32'h1 << (i + 16));
            exp_s = exp_s & ~(16'h1 << i);
            rd(STAT, v);
            check($sformatf("R1 clear bit %0d", i), v, {16'h0, exp_s});
        end
        // R2 positions: pause, dead, branch-taken, device byte 0
        bus_wr(CTRL, 32'h49FF_4900 | 32'h0000_00C3);
        rd(STAT, v);
        check("R2 field positions", v, 32'h0000_49C3);
        exp_s = 16'h49C3;

        // R1/R3 pseudo-random masked writes against arithmetic model
        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] m;
            seed = seed * 32'd1664525 + 32'd1013904223;
            m = seed[31:16] & 16'h7FFF;
            bus_wr(CTRL, {m, seed[15:0]});
            exp_s = (exp_s & ~(m & WMASK)) | (seed[15:0] & m & WMASK);
            rd(STAT, v);
            check("R1 R3 random masked write", v, {16'h0, exp_s});
        end

        // R10 write elsewhere is ignored
        bus_wr(2, 32'hFFFF_FFFF);
        rd(STAT, v);
        check("R10 other address write", v, {16'h0, exp_s});
        rd(3, v);
        check("R10 other address read", v, 32'h0);

        // R8 device port alone, then colliding with a partial bus write
        do_reset();
        @(negedge clk);
        dev_stat_we = 1'b1; dev_stat_wdata = 8'h5A;
        @(negedge clk);
        dev_stat_we = 1'b0;
        rd(STAT, v);
        check("R8 device load", v, 32'h0000_005A);
        both_wr(32'h000F_0003, 8'hA5);
        rd(STAT, v);
        check("R8 bus wins per bit", v, 32'h0000_00A3);

        // R9 reset clears everything
        do_reset();
        rd(STAT, v);
        check("R9 reset clears", v, 32'h0);

        // R4 start
        bus_wr(CTRL, 32'h8000_8000);
        rd(STAT, v);
        check("R4 run visible", v, 32'h0000_8000);
        act_check("R4 active not yet", 1'b0);
        @(negedge clk);
        act_check("R4 active one cycle later", 1'b1);

        // R5/R6 stop with flush cleared
        bus_wr(CTRL, 32'hA000_0000);
        for (int k = 0; k <= D; k++) begin
            act_check($sformatf("R5 drain active k=%0d", k), 1'b1);
            @(negedge clk);
        end
        act_check("R6 stop done active", 1'b0);
        rd(STAT, v);
        check("R6 stop done flush", {31'b0, v[13]}, 32'h0);

        // R12 flush while running
        bus_wr(CTRL, 32'h8000_8000);
        @(negedge clk);
        act_check("R12 running", 1'b1);
        bus_wr(CTRL, 32'h2000_2000);
        rd(STAT, v);
        check("R12 flush set", {31'b0, v[13]}, 32'h1);
        for (int k = 0; k <= D; k++) begin
            act_check($sformatf("R12 drain k=%0d", k), 1'b1);
            @(negedge clk);
        end
        act_check("R12 drain over", 1'b0);
        rd(STAT, v);
        check("R12 flush self-cleared", {31'b0, v[13]}, 32'h0);
        @(negedge clk);
        act_check("R12 restart", 1'b1);

        // R5/R4 pause
        bus_wr(CTRL, 32'h4000_4000);
        for (int k = 0; k <= D; k++) begin
            act_check($sformatf("R5 pause drain k=%0d", k), 1'b1);
            @(negedge clk);
        end
        act_check("R5 pause drain over", 1'b0);
        repeat (3) @(negedge clk);
        act_check("R4 paused stays idle", 1'b0);
        bus_wr(CTRL, 32'h4000_0000);
        act_check("R4 unpause same cycle", 1'b0);
        @(negedge clk);
        act_check("R4 unpause restart", 1'b1);

        // R7 reset-style write while running
        bus_wr(CTRL, 32'h1800_1800);
        bus_wr(CTRL, 32'hFC00_0000);
        act_check("R7 abort active", 1'b0);
        rd(STAT, v);
        check("R7 reset write status", v, 32'h0);
        bus_wr(CTRL, 32'h0400_0400);
        act_check("R7 active write ignored", 1'b0);
        @(negedge clk);
        act_check("R7 active write ignored later", 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nchk++;
                nerr++;
                $display("FAIL all watchdog got=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule